// File: doc/BRIEF.md
# External Bus Cycle Sequencer with READY Extension

This block turns single read or write requests from a processor core into timed strobe sequences on an external memory bus. Each bus cycle starts with an address-latch phase. During that phase the latch strobe is high for one or two clocks and the address is driven. A command phase follows, with the read or write strobe active low. The command phase first runs a programmed number of fixed wait states. After that, an active-low READY input decides when the cycle ends. Once the command strobe is released, zero, one or two trailing clocks are added, depending on the bus mode, before the core is told the request is complete.

READY can be taken straight from the pin, which gives the shortest cycle for a source that is timed to the bus clock. It can also pass through a two-flop synchronizer for a source with no timing relation to the clock, at the cost of extra latency. The synchronizer is reloaded with "not ready" whenever a request is accepted. A READY level left over from the previous cycle therefore cannot end the new cycle early.

The core presents one request at a time with a valid/ready handshake, together with mode bits that apply to that cycle only. A request held valid while a cycle finishes is taken in the same clock that reports completion, so cycles can run back to back.

Top module: `ebus_seq`

## Requirements
- R1: After reset, `bus_ale` is 0, `bus_rd_n` and `bus_wr_n` are 1, `bus_addr_oe`, `bus_data_oe` and `done` are 0, and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `bus_ale` is high for 1 cycle if `req_ale_long` is 0, or for 2 cycles if it is 1, with `bus_addr` equal to the request address. The command strobe falls in the cycle right after `bus_ale` drops, and the two are never active together.
- R3: With `req_write` = 0 (read), only `bus_rd_n` goes low and `bus_data_oe` stays 0. With `req_write` = 1 (write), only `bus_wr_n` goes low, and `bus_data_oe` is 1 with `bus_dout` equal to the request data in every cycle the strobe is low.
- R4: The command strobe stays low for at least `req_wait` + 1 cycles. READY is not sampled until all `req_wait` fixed wait states have run.
- R5: With `req_async` = 0, READY is sampled directly at each clock edge ending a command cycle from cycle `req_wait`+1 onward. A high level (not ready) adds a cycle and a low level ends the command phase. If `ready_n` is high for the first H command cycles and low afterwards, the strobe is low for max(`req_wait`+1, H+1) cycles.
- R6: With `req_async` = 1, READY passes through two flops before it is sampled. If `ready_n` is high in the address phase and for the first H ≥ 1 command cycles and low afterwards, the strobe is low for max(`req_wait`+1, H+3) cycles.
- R7: The synchronizer is reset to "not ready" when a request is accepted. With `req_async` = 1, `req_wait` = 0, `req_ale_long` = 0 and `ready_n` already low when the request is accepted, the strobe is low for 2 cycles, against 1 cycle for `req_async` = 0 under the same conditions.
- R8: For a read, `rdata` holds the `bus_din` value present in the last cycle the strobe is low. It keeps that value while `done` is high, even if `bus_din` changes after the strobe rises.
- R9: Between the strobe rising and `done`, the number of trailing cycles is `req_mux` + `req_tristate`: 0 for a demultiplexed bus without the tristate wait state, 2 for a multiplexed bus with it. A request accepted at edge 0 shows `done` in cycle A + C + T + 1, where A, C and T are the latch, strobe and trailing cycle counts.
- R10: With `req_mux` = 1, `bus_addr_oe` is 0 throughout the command phase. With `req_mux` = 0, it stays 1 throughout the command phase.
- R11: `done` is high for exactly one cycle per request, and only while `req_ready` is 1. `req_ready` is 0 from acceptance until that cycle.
- R12: A request held valid is accepted at the end of the `done` cycle. The strobe of the following cycle then falls T + 1 + A' cycles after the previous strobe rose, where T is the previous cycle's trailing count and A' is the new cycle's latch length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus reference clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_wait | input | WAIT_W | Fixed command wait states |
| req_async | input | 1 | 1 = synchronize READY through two flops |
| req_mux | input | 1 | 1 = multiplexed bus, adds one trailing cycle |
| req_tristate | input | 1 | 1 = add the tristate trailing cycle |
| req_ale_long | input | 1 | 1 = two-cycle address latch phase |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| ready_n | input | 1 | Active-low READY from the bus |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | ADDR_W | Address driven to the bus |
| bus_addr_oe | output | 1 | Address output enable |
| bus_dout | output | DATA_W | Write data to the bus |
| bus_data_oe | output | 1 | Data output enable |
| bus_din | input | DATA_W | Read data from the bus |

## Verification
Checks that hold in every cycle are properties. They cover the mutual exclusion of the two command strobes and of the latch strobe against them, the data enable following the write strobe and never the read strobe, the latch strobe only rising after a handshake, and the completion pulse lasting one cycle while the sequencer is idle. Cycle counts can only be shown by the bench's scenarios, because they depend on the mode bits and on when the bench releases READY. These scenarios cover the wait-state floor, the synchronous and synchronized READY latencies, the stale-READY case, the four trailing-delay combinations, address release on a multiplexed bus, read data capture, and back-to-back spacing.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_CMD   = 2'd2,
    ST_TRAIL = 2'd3
  } ebus_state_e;

  typedef struct packed {
    logic write;
    logic async_rdy;
    logic mux;
    logic tri_ws;
    logic ale_long;
  } ebus_mode_t;

endpackage

// File: rtl/ebus_rdy_sync.sv
module ebus_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic ready_n,
  output logic ready_n_sync
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst || clear) chain <= 1'b1;
        else              chain <= ready_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst || clear) chain <= '1;
        else              chain <= {chain[STAGES-2:0], ready_n};
      end
    end
  endgenerate

  assign ready_n_sync = chain[STAGES-1];

endmodule

// File: rtl/ebus_datapath.sv
module ebus_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_dout <= '0;
    end else if (load) begin
      bus_addr <= req_addr;
      bus_dout <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (capture) rdata <= bus_din;
  end

endmodule

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
  import ebus_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  ebus_mode_t        mode,
  input  logic [WAIT_W-1:0] wait_cnt,
  input  logic              ready_n,
  input  logic              ready_n_sync,
  output logic              req_ready,
  output logic              accept,
  output logic              rd_capture,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              addr_oe,
  output logic              data_oe,
  output logic              done
);

  ebus_state_e       state;
  ebus_mode_t        mode_q;
  logic [WAIT_W-1:0] wcnt;
  logic [1:0]        tcnt;
  logic              ale_second;
  logic              rdy_n_eff;
  logic              cmd_end;
  logic [1:0]        trail_len;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_ready && req_valid;
  assign rdy_n_eff  = mode_q.async_rdy ? ready_n_sync : ready_n;
  assign cmd_end    = (state == ST_CMD) && (wcnt == '0) && !rdy_n_eff;
  assign rd_capture = cmd_end && !mode_q.write;
  assign trail_len  = {1'b0, mode_q.mux} + {1'b0, mode_q.tri_ws};

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mode_q     <= '0;
      wcnt       <= '0;
      tcnt       <= '0;
      ale_second <= 1'b0;
      ale        <= 1'b0;
      rd_n       <= 1'b1;
      wr_n       <= 1'b1;
      addr_oe    <= 1'b0;
      data_oe    <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            mode_q     <= mode;
            wcnt       <= wait_cnt;
            ale_second <= 1'b0;
            ale        <= 1'b1;
            addr_oe    <= 1'b1;
            state      <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (mode_q.ale_long && !ale_second) begin
            ale_second <= 1'b1;
          end else begin
            ale     <= 1'b0;
            rd_n    <= mode_q.write;
            wr_n    <= !mode_q.write;
            data_oe <= mode_q.write;
            addr_oe <= !mode_q.mux;
            state   <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
          end else if (cmd_end) begin
            rd_n    <= 1'b1;
            wr_n    <= 1'b1;
            data_oe <= 1'b0;
            addr_oe <= 1'b0;
            if (trail_len == 2'd0) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              tcnt  <= trail_len - 2'd1;
              state <= ST_TRAIL;
            end
          end
        end
        ST_TRAIL: begin
          if (tcnt == 2'd0) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            tcnt <= tcnt - 2'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int WAIT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [WAIT_W-1:0] req_wait,
  input  logic              req_async,
  input  logic              req_mux,
  input  logic              req_tristate,
  input  logic              req_ale_long,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  input  logic              ready_n,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_addr_oe,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_data_oe,
  input  logic [DATA_W-1:0] bus_din
);

  ebus_mode_t mode;
  logic       accept;
  logic       rd_capture;
  logic       ready_n_sync;

  assign mode.write     = req_write;
  assign mode.async_rdy = req_async;
  assign mode.mux       = req_mux;
  assign mode.tri_ws    = req_tristate;
  assign mode.ale_long  = req_ale_long;

  ebus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst          (rst),
    .clear        (accept),
    .ready_n      (ready_n),
    .ready_n_sync (ready_n_sync)
  );

  ebus_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .mode         (mode),
    .wait_cnt     (req_wait),
    .ready_n      (ready_n),
    .ready_n_sync (ready_n_sync),
    .req_ready    (req_ready),
    .accept       (accept),
    .rd_capture   (rd_capture),
    .ale          (bus_ale),
    .rd_n         (bus_rd_n),
    .wr_n         (bus_wr_n),
    .addr_oe      (bus_addr_oe),
    .data_oe      (bus_data_oe),
    .done         (done)
  );

  ebus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .capture   (rd_capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .bus_din   (bus_din),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .rdata     (rdata)
  );

endmodule

// File: rtl/ebus_seq_checker.sv
module ebus_seq_checker (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic bus_ale,
  input logic bus_rd_n,
  input logic bus_wr_n,
  input logic bus_data_oe
);

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));

  p_ale_no_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> (bus_rd_n && bus_wr_n));

  p_ale_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ale) |-> $past(req_valid && req_ready));

  p_write_drives_r3: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> bus_data_oe);

  p_read_no_drive_r3: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_data_oe);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

endmodule

bind ebus_seq ebus_seq_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .done        (done),
  .bus_ale     (bus_ale),
  .bus_rd_n    (bus_rd_n),
  .bus_wr_n    (bus_wr_n),
  .bus_data_oe (bus_data_oe)
);

// File: tb/ebus_seq_test.sv
`timescale 1ns/1ps
module ebus_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  req_wait = '0;
  logic        req_async = 1'b0;
  logic        req_mux = 1'b0;
  logic        req_tristate = 1'b0;
  logic        req_ale_long = 1'b0;
  logic        done;
  logic [15:0] rdata;
  logic        ready_n = 1'b1;
  logic        bus_ale, bus_rd_n, bus_wr_n, bus_addr_oe, bus_data_oe;
  logic [15:0] bus_addr, bus_dout;
  logic [15:0] bus_din = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int m_ale, m_low, m_trail, m_total, m_addr_bad, m_wd_bad, m_other;
  int m_aoe_cmd, m_busy_rdy, m_done2;
  logic [15:0] m_rdata;

  always #5 clk = ~clk;

  ebus_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wait(req_wait), .req_async(req_async), .req_mux(req_mux),
    .req_tristate(req_tristate), .req_ale_long(req_ale_long),
    .done(done), .rdata(rdata), .ready_n(ready_n), .bus_ale(bus_ale),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_addr(bus_addr),
    .bus_addr_oe(bus_addr_oe), .bus_dout(bus_dout),
    .bus_data_oe(bus_data_oe), .bus_din(bus_din)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Starts just after a negedge with the sequencer idle; ends the same way.
  task automatic do_cycle(input logic wr, input logic [15:0] a, input logic [15:0] wd,
                          input int w, input logic as, input logic mx, input logic tw,
                          input logic al, input int h, input logic [15:0] din);
    logic strobe;
    m_ale = 0; m_low = 0; m_trail = 0; m_total = 0; m_addr_bad = 0; m_wd_bad = 0;
    m_other = 0; m_aoe_cmd = 0; m_busy_rdy = 0; m_rdata = '0;
    req_write = wr; req_addr = a; req_wdata = wd; req_wait = w[3:0];
    req_async = as; req_mux = mx; req_tristate = tw; req_ale_long = al;
    bus_din = din;
    if (h > 0) ready_n = 1'b1;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k < 200; k++) begin
      strobe = wr ? bus_wr_n : bus_rd_n;
      if (done) begin
        m_total = k;
        m_rdata = rdata;
        break;
      end
      if (req_ready) m_busy_rdy++;
      if (bus_ale) begin
        m_ale++;
        if (bus_addr != a) m_addr_bad++;
      end
      if ((wr ? bus_rd_n : bus_wr_n) == 1'b0) m_other++;
      if (!strobe) begin
        m_low++;
        if (bus_addr_oe) m_aoe_cmd++;
        if (wr && (!bus_data_oe || bus_dout != wd)) m_wd_bad++;
        if (!wr && bus_data_oe) m_wd_bad++;
        ready_n = (m_low <= h);
      end else if (m_low > 0) begin
        m_trail++;
        bus_din = ~din;
      end
      @(negedge clk);
    end
    @(negedge clk);
    m_done2 = done;
  endtask

  task automatic t_reset;
    chk("R1 req_ready", req_ready, 1);
    chk("R1 ale", bus_ale, 0);
    chk("R1 rd_n", bus_rd_n, 1);
    chk("R1 wr_n", bus_wr_n, 1);
    chk("R1 oe", {bus_addr_oe, bus_data_oe}, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_basic_read;
    do_cycle(1'b0, 16'h1234, 16'h0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 16'hBEEF);
    chk("R2 ale cycles short", m_ale, 1);
    chk("R2 address during ale", m_addr_bad, 0);
    chk("R3 read: no write strobe", m_other, 0);
    chk("R3 read: data not driven", m_wd_bad, 0);
    chk("R4 strobe low W=0", m_low, 1);
    chk("R9 total cycles", m_total, 3);
    chk("R8 read data", m_rdata, 16'hBEEF);
    chk("R11 done single", m_done2, 0);
    chk("R11 busy not ready", m_busy_rdy, 0);
  endtask

  task automatic t_long_write;
    do_cycle(1'b1, 16'h0F0F, 16'hA5A5, 3, 1'b0, 1'b0, 1'b0, 1'b1, 0, 16'h0);
    chk("R2 ale cycles long", m_ale, 2);
    chk("R2 address during long ale", m_addr_bad, 0);
    chk("R3 write data driven", m_wd_bad, 0);
    chk("R3 write: no read strobe", m_other, 0);
    chk("R4 strobe low W=3", m_low, 4);
    chk("R9 total long write", m_total, 7);
  endtask

  task automatic t_sync_ready;
    do_cycle(1'b0, 16'h0042, 16'h0, 1, 1'b0, 1'b0, 1'b0, 1'b0, 4, 16'h1357);
    chk("R5 sync ready H=4 W=1", m_low, 5);
    chk("R8 read data after extension", m_rdata, 16'h1357);
    do_cycle(1'b1, 16'h0043, 16'h2468, 6, 1'b0, 1'b0, 1'b0, 1'b0, 2, 16'h0);
    chk("R5 sync ready H=2 W=6", m_low, 7);
  endtask

  task automatic t_async_ready;
    do_cycle(1'b0, 16'h0100, 16'h0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 2, 16'hC0DE);
    chk("R6 async H=2 W=0", m_low, 5);
    do_cycle(1'b1, 16'h0101, 16'h7777, 5, 1'b1, 1'b0, 1'b0, 1'b0, 1, 16'h0);
    chk("R6 async H=1 W=5", m_low, 6);
  endtask

  task automatic t_stale_ready;
    do_cycle(1'b0, 16'h0200, 16'h0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 16'h1111);
    do_cycle(1'b0, 16'h0201, 16'h0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 16'h2222);
    chk("R7 async stale ready", m_low, 2);
    do_cycle(1'b0, 16'h0202, 16'h0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 16'h3333);
    chk("R7 sync same conditions", m_low, 1);
  endtask

  task automatic t_trailing;
    for (int mx = 0; mx < 2; mx++) begin
      for (int tw = 0; tw < 2; tw++) begin
        do_cycle(1'(mx), 1'b0 ? 16'h0 : 16'h0300, 16'h5A5A, 1, 1'b0, 1'(mx), 1'(tw),
                 1'b0, 0, 16'h0);
        chk($sformatf("R9 trailing mux=%0d tri=%0d", mx, tw), m_trail, mx + tw);
        chk($sformatf("R9 total mux=%0d tri=%0d", mx, tw), m_total, 1 + 2 + mx + tw + 1);
        chk($sformatf("R10 addr_oe in command mux=%0d", mx), m_aoe_cmd, (mx != 0) ? 0 : 2);
      end
    end
  endtask

  task automatic t_back_to_back;
    bit low1, rose1, b2_ok;
    int gap;
    low1 = 0; rose1 = 0; gap = 0; b2_ok = 0;
    ready_n = 1'b0;
    req_write = 1'b0; req_addr = 16'h0400; req_wait = 4'd0; req_async = 1'b0;
    req_mux = 1'b1; req_tristate = 1'b1; req_ale_long = 1'b0;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_write = 1'b1; req_addr = 16'h0500; req_wdata = 16'h9999;
    req_mux = 1'b0; req_tristate = 1'b0; req_ale_long = 1'b1;
    for (int k = 0; k < 60; k++) begin
      if (!rose1) begin
        if (!bus_rd_n) low1 = 1;
        else if (low1) rose1 = 1;
      end
      if (rose1) begin
        if (bus_ale) req_valid = 1'b0;
        if (!bus_wr_n) begin
          b2_ok = 1;
          break;
        end
        gap++;
      end
      @(negedge clk);
    end
    chk("R12 second cycle started", b2_ok, 1);
    chk("R12 back-to-back gap", gap, 5);
    req_valid = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
    chk("R12 idle after second cycle", req_ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic_read();
    t_long_write();
    t_sync_ready();
    t_async_ready();
    t_stale_ready();
    t_trailing();
    t_back_to_back();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule